// File: doc/BRIEF.md
# Buffered Input Capture Channel Group

This block timestamps pin transitions for a group of input channels that all read one free-running counter. Each channel watches one pin through a two-flop synchroniser and a selectable edge detector. On a qualifying edge the channel stores the counter value in its capture register. The channel can also run as a two-entry queue: the older value drops into a holding register behind the capture register, so two stamps can be collected before software has to read either one.

Each channel has its own protection bit that keeps stored stamps from being replaced. A capture or holding register only takes a new value once the stored one has been read (or, for the capture register, passed down to the holding register). A global flag mode makes a queued channel raise its flag once per pair of captures instead of on every capture. A channel in the upper half of the group can take its events from the pin of its partner in the lower half. Software reaches everything through a byte-wide register bus. Sixteen-bit values are read high byte first, and the high-byte read latches the low byte so that the two halves always belong together.

Top module: `ecap_group`

## Requirements
- R1: The counter is 0 in reset and advances by one on every clock, wrapping at its width. A read of address 0x04 returns its high byte; a following read of 0x05 returns the low byte that was latched with it.
- R2: Each channel's mode byte at 0x08+ch selects its edge in bits [1:0]: 0 none, 1 rising, 2 falling, 3 both. A channel only captures on the selected edge. The stored stamp is the counter value seen at the clock edge that first samples the pin change, plus 2.
- R3: Protection bits sit at 0x01, bit ch for channel ch. Outside queue mode, with the bit clear, every edge replaces the capture register. With the bit set, an edge is ignored while the capture register holds an unread stamp. A read of its high byte empties it.
- R4: Queue mode is control bit 1. In queue mode an accepted edge that meets a full capture register first moves that value into the holding register. It then loads the new stamp in the same clock.
- R5: In queue mode with protection set, an edge that finds both registers full is dropped. An edge that finds the capture register empty loads it and leaves a full holding register untouched. The holding register is emptied only by a read of its high byte.
- R6: The flags at 0x03, bit ch, are set by each capture that counts. Writing 1 to a bit clears it; writing 0 leaves it unchanged.
- R7: With flag mode (control bit 3) and queue mode both set, a channel's flag is set only by a capture that moves a stamp into the holding register. When both registers start empty and protection is on, this means one flag per two captures.
- R8: Control bit 4+k links pair k. Channel k+NCH/2 then takes its capture events from pin k through channel k's edge detector, and its own pin has no effect.
- R9: With one_shot_cfg high, the control register accepts only the first write after reset. With it low, every write is accepted. Reads are always allowed.
- R10: The capture register of channel ch is at 0x10+4*ch (high) and +1 (low), and its holding register is at +2 (high) and +3 (low). A low-byte read returns the byte latched by the last high-byte read, even if the register has changed since.
- R11: After reset the control, protection, mode, flag, capture and holding registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| one_shot_cfg | input | 1 | When high, the control register can be written only once after reset |
| pins | input | NCH | Asynchronous capture pins |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
A wrong full/empty state shows up at the very next edge on that channel. A stamp is dropped when it should be kept, or a stored one is overwritten, and the next high-then-low read shows a counter value off by at least one pin interval. A wrong move into the holding register shows as a holding-register read that does not equal the earlier stamp. In flag mode it also shows in the flag byte one capture early or late. A fault in sharing or edge selection shows in the flag byte within four clocks of the pin change, before any capture register is read.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  localparam int CTRL_QUEUE_BIT = 1;
  localparam int CTRL_FMODE_BIT = 3;
  localparam int CTRL_LINK_LSB  = 4;

  localparam logic [7:0] A_CTRL      = 8'h00;
  localparam logic [7:0] A_PROT      = 8'h01;
  localparam logic [7:0] A_FLAGS     = 8'h03;
  localparam logic [7:0] A_CNT_HI    = 8'h04;
  localparam logic [7:0] A_CNT_LO    = 8'h05;
  localparam logic [7:0] A_MODE_BASE = 8'h08;
  localparam logic [7:0] A_CAP_BASE  = 8'h10;

  // edge qualification between the previous and current synchronised level
  function automatic logic edge_hit(edge_mode_e m, logic prev, logic cur);
    logic rise, fall;
    rise = !prev && cur;
    fall = prev && !cur;
    case (m)
      EDGE_RISE: return rise;
      EDGE_FALL: return fall;
      EDGE_ANY:  return rise || fall;
      default:   return 1'b0;
    endcase
  endfunction

  // byte address of a channel's register slot (0..3 within the channel)
  function automatic logic [7:0] slot_addr(int ch, int slot);
    return 8'(int'(A_CAP_BASE) + 4 * ch + slot);
  endfunction
endpackage

// File: rtl/ecap_counter.sv
module ecap_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // R1: free-running increment by exactly one
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt == CW'($past(cnt) + 1'b1));
endmodule

// File: rtl/ecap_edge.sv
module ecap_edge
  import ecap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  edge_mode_e mode,
  output logic       hit_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign hit_o = edge_hit(mode, s3, s2);

  // R2: a detected edge always corresponds to a level change after the synchroniser
  p_hit_needs_change_r2: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (s2 != s3));
endmodule

// File: rtl/ecap_chan.sv
module ecap_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          queue_en,
  input  logic          flag_mode,
  input  logic          protect,
  input  logic [CW-1:0] cnt,
  input  logic          rd_cap,
  input  logic          rd_hold,
  output logic [CW-1:0] cap,
  output logic [CW-1:0] hold,
  output logic          cap_full,
  output logic          hold_full,
  output logic          flag_set
);
  logic move_ok, take, do_move;

  always_comb begin
    move_ok  = queue_en && cap_full && (!protect || !hold_full);
    take     = hit && (!protect || !cap_full || move_ok);
    do_move  = take && move_ok;
    flag_set = take && (!(queue_en && flag_mode) || do_move);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap       <= '0;
      hold      <= '0;
      cap_full  <= 1'b0;
      hold_full <= 1'b0;
    end else begin
      if (take) begin
        cap      <= cnt;
        cap_full <= 1'b1;
      end else if (rd_cap) begin
        cap_full <= 1'b0;
      end
      if (do_move) begin
        hold      <= cap;
        hold_full <= 1'b1;
      end else if (rd_hold) begin
        hold_full <= 1'b0;
      end
    end
  end

  // R3: a protected, unread stamp outside queue mode is never replaced
  p_cap_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (protect && cap_full && !queue_en) |=> $stable(cap));

  // R5: a protected, unread holding value is never replaced
  p_hold_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (protect && hold_full) |=> $stable(hold));

  // R7: in paired flag mode a flag always comes with a full holding register
  p_flag_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_set && queue_en && flag_mode) |=> hold_full);
endmodule

// File: rtl/ecap_group.sv
module ecap_group
  import ecap_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           one_shot_cfg,
  input  logic [NCH-1:0] pins,
  input  logic [7:0]     bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata
);
  localparam int HALF = NCH / 2;
  localparam logic [7:0] CTRL_MASK =
    8'(((1 << HALF) - 1) << CTRL_LINK_LSB) |
    8'(1 << CTRL_QUEUE_BIT) | 8'(1 << CTRL_FMODE_BIT);

  logic [7:0]     ctrl;
  logic           ctrl_locked;
  logic [NCH-1:0] prot;
  logic [NCH-1:0] flags;
  edge_mode_e     mode_q [NCH];
  logic [7:0]     lo_latch;

  logic [CW-1:0]  cnt;
  logic [NCH-1:0] own_hit, eff_hit, flag_set, rd_cap, rd_hold;
  logic [NCH-1:0] cap_full, hold_full;
  logic [CW-1:0]  cap_w  [NCH];
  logic [CW-1:0]  hold_w [NCH];

  logic           ctrl_wr_ok;
  logic [NCH-1:0] flag_clr;
  logic [7:0]     rd_val, lat_val;
  logic           lat_ld;

  ecap_counter #(.CW(CW)) u_cnt (.clk(clk), .rst(rst), .cnt(cnt));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ecap_edge u_edge (
      .clk(clk), .rst(rst), .pin_i(pins[c]), .mode(mode_q[c]), .hit_o(own_hit[c])
    );

    if (c >= HALF) begin : g_linked
      assign eff_hit[c] = ctrl[CTRL_LINK_LSB + c - HALF] ? own_hit[c - HALF] : own_hit[c];
    end else begin : g_plain
      assign eff_hit[c] = own_hit[c];
    end

    ecap_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst(rst), .hit(eff_hit[c]),
      .queue_en(ctrl[CTRL_QUEUE_BIT]), .flag_mode(ctrl[CTRL_FMODE_BIT]),
      .protect(prot[c]), .cnt(cnt), .rd_cap(rd_cap[c]), .rd_hold(rd_hold[c]),
      .cap(cap_w[c]), .hold(hold_w[c]), .cap_full(cap_full[c]),
      .hold_full(hold_full[c]), .flag_set(flag_set[c])
    );

    // R6: writing 1 with no simultaneous capture clears the flag
    p_flag_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A_FLAGS && bus_wdata[c] && !flag_set[c]) |=> !flags[c]);
  end

  assign ctrl_wr_ok = bus_wr && (bus_addr == A_CTRL) && !(one_shot_cfg && ctrl_locked);
  assign flag_clr   = (bus_wr && bus_addr == A_FLAGS) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl        <= '0;
      ctrl_locked <= 1'b0;
      prot        <= '0;
      flags       <= '0;
      for (int c = 0; c < NCH; c++) mode_q[c] <= EDGE_OFF;
    end else begin
      if (ctrl_wr_ok) begin
        ctrl        <= bus_wdata & CTRL_MASK;
        ctrl_locked <= 1'b1;
      end
      if (bus_wr && bus_addr == A_PROT) prot <= bus_wdata[NCH-1:0];
      for (int c = 0; c < NCH; c++)
        if (bus_wr && bus_addr == 8'(int'(A_MODE_BASE) + c))
          mode_q[c] <= edge_mode_e'(bus_wdata[1:0]);
      flags <= (flags & ~flag_clr) | flag_set;
    end
  end

  // read decode: high bytes latch their low byte, low bytes return the latch
  always_comb begin
    rd_val  = '0;
    lat_ld  = 1'b0;
    lat_val = '0;
    rd_cap  = '0;
    rd_hold = '0;
    if (bus_addr == A_CTRL)   rd_val = ctrl;
    if (bus_addr == A_PROT)   rd_val = 8'(prot);
    if (bus_addr == A_FLAGS)  rd_val = 8'(flags);
    if (bus_addr == A_CNT_HI) begin
      rd_val  = 16'(cnt) >> 8;
      lat_ld  = 1'b1;
      lat_val = 8'(cnt);
    end
    if (bus_addr == A_CNT_LO) rd_val = lo_latch;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == 8'(int'(A_MODE_BASE) + c)) rd_val = {6'b0, mode_q[c]};
      if (bus_addr == slot_addr(c, 0)) begin
        rd_val    = 8'(16'(cap_w[c]) >> 8);
        lat_ld    = 1'b1;
        lat_val   = 8'(cap_w[c]);
        rd_cap[c] = bus_rd;
      end
      if (bus_addr == slot_addr(c, 1)) rd_val = lo_latch;
      if (bus_addr == slot_addr(c, 2)) begin
        rd_val     = 8'(16'(hold_w[c]) >> 8);
        lat_ld     = 1'b1;
        lat_val    = 8'(hold_w[c]);
        rd_hold[c] = bus_rd;
      end
      if (bus_addr == slot_addr(c, 3)) rd_val = lo_latch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      lo_latch  <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_val;
      if (lat_ld) lo_latch <= lat_val;
    end
  end

  // R9: a locked control register ignores further writes
  p_ctrl_lock_r9: assert property (@(posedge clk) disable iff (rst)
    (one_shot_cfg && ctrl_locked && bus_wr && bus_addr == A_CTRL) |=> $stable(ctrl));
endmodule

// File: tb/ecap_group_test.sv
module ecap_group_test;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           one_shot = 1'b0;
  logic [NCH-1:0] pins = '0;
  logic [7:0]     addr = '0;
  logic [7:0]     wdata = '0;
  logic           wr = 1'b0;
  logic           rd = 1'b0;
  logic [7:0]     rdata;

  always #10 clk = ~clk;

  ecap_group #(.NCH(NCH), .CW(16)) uut (
    .clk(clk), .rst(rst), .one_shot_cfg(one_shot), .pins(pins),
    .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  // bench time base: 0 in reset, +1 per clock (R1)
  logic [15:0] cyc;
  always @(posedge clk) begin
    if (rst) cyc <= '0;
    else     cyc <= cyc + 16'd1;
  end

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard driver side
  task automatic push(input string req, input logic [15:0] v);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // scoreboard monitor side
  task automatic pop_chk(input logic [15:0] act);
    if (exp_q.size() == 0) chk("scoreboard", act, 16'hxxxx);
    else chk(tag_q.pop_front(), act, exp_q.pop_front());
  endtask

  task automatic bwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic rd16(input logic [7:0] base, output logic [15:0] v);
    logic [7:0] h, l;
    brd(base, h);
    brd(8'(base + 8'd1), l);
    v = {h, l};
  endtask

  task automatic pin_set(input int ch, input logic v, output logic [15:0] st);
    @(negedge clk);
    pins[ch] = v;
    st = cyc + 16'd2;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input int ch, output logic [15:0] st);
    logic [15:0] dummy;
    pin_set(ch, 1'b1, st);
    pin_set(ch, 1'b0, dummy);
  endtask

  function automatic logic [7:0] cap_a(input int ch);
    return 8'(8'h10 + 4 * ch);
  endfunction

  function automatic logic [7:0] hold_a(input int ch);
    return 8'(8'h12 + 4 * ch);
  endfunction

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, s, s2, st;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    brd(8'h00, b); chk("R11 ctrl", 16'(b), 16'h0);
    brd(8'h03, b); chk("R11 flags", 16'(b), 16'h0);
    brd(8'h01, b); chk("R11 protect", 16'(b), 16'h0);
    rd16(cap_a(0), v); chk("R11 capture", v, 16'h0);

    // R1 counter read, R10 coherent low byte
    @(negedge clk); addr = 8'h04; rd = 1'b1; s = cyc;
    @(negedge clk); rd = 1'b0; b = rdata;
    brd(8'h05, v[7:0]);
    chk("R1 counter", {b, v[7:0]}, s);

    // R2 rising capture, R6 flag set and write-1 clear
    bwr(8'h08, 8'd1);
    pulse(0, s); push("R2 rising stamp", s);
    brd(8'h03, b); chk("R6 flag set", 16'(b), 16'h1);
    rd16(cap_a(0), v); pop_chk(v);
    bwr(8'h03, 8'h00);
    brd(8'h03, b); chk("R6 write 0 keeps flag", 16'(b), 16'h1);
    bwr(8'h03, 8'h01);
    brd(8'h03, b); chk("R6 write 1 clears", 16'(b), 16'h0);

    // R2 falling-only then both edges on ch1
    bwr(8'h09, 8'd2);
    pin_set(1, 1'b1, st);
    brd(8'h03, b); chk("R2 rise ignored in falling mode", 16'(b), 16'h0);
    pin_set(1, 1'b0, s); push("R2 falling stamp", s);
    brd(8'h03, b); chk("R2 falling flag", 16'(b), 16'h2);
    rd16(cap_a(1), v); pop_chk(v);
    bwr(8'h09, 8'd3);
    pin_set(1, 1'b1, s); push("R2 both-edge stamp", s);
    rd16(cap_a(1), v); pop_chk(v);
    bwr(8'h03, 8'h0F);

    // R3 protection outside queue mode on ch0
    bwr(8'h01, 8'h01);
    pulse(0, s); push("R3 protected keeps first", s);
    pulse(0, st);
    rd16(cap_a(0), v); pop_chk(v);
    pulse(0, s); push("R3 capture after read", s);
    rd16(cap_a(0), v); pop_chk(v);
    // R3 overwrite on unprotected ch1 (pin1 is high)
    pin_set(1, 1'b0, st);
    pin_set(1, 1'b1, s); push("R3 overwrite latest", s);
    rd16(cap_a(1), v); pop_chk(v);

    // R10 low byte comes from the latch
    brd(cap_a(1), b);
    pin_set(1, 1'b0, s2);
    brd(8'(cap_a(1) + 8'd1), b); chk("R10 latched low byte", 16'(b), 16'(s[7:0]));
    rd16(cap_a(1), v); chk("R10 new value", v, s2);

    // R4 queue mode on unprotected ch1 (pin1 low)
    bwr(8'h00, 8'h02);
    pin_set(1, 1'b1, s);
    pin_set(1, 1'b0, s2);
    push("R4 capture newest", s2); push("R4 holding older", s);
    rd16(cap_a(1), v); pop_chk(v);
    rd16(hold_a(1), v); pop_chk(v);

    // R5 protected queue on ch0
    begin
      logic [15:0] f1, f2, f3, f4, f5;
      pulse(0, f1);
      pulse(0, f2);
      pulse(0, f3);
      push("R5 full pair drops edge", f2);
      rd16(cap_a(0), v); pop_chk(v);
      pulse(0, f4);
      push("R5 holding untouched", f1);
      rd16(hold_a(0), v); pop_chk(v);
      pulse(0, f5);
      push("R4 move after holding read", f4);
      push("R4 newest in capture", f5);
      rd16(hold_a(0), v); pop_chk(v);
      rd16(cap_a(0), v); pop_chk(v);
    end

    // R7 paired flag mode, R9 rewrite accepted while one_shot_cfg is low
    bwr(8'h00, 8'h0A);
    brd(8'h00, b); chk("R9 rewrite accepted", 16'(b), 16'h0A);
    bwr(8'h03, 8'h0F);
    pulse(0, s);
    brd(8'h03, b); chk("R7 no flag after first", 16'(b), 16'h0);
    pulse(0, s2);
    brd(8'h03, b); chk("R7 flag after second", 16'(b), 16'h1);
    push("R7 holding first", s); push("R7 capture second", s2);
    rd16(hold_a(0), v); pop_chk(v);
    rd16(cap_a(0), v); pop_chk(v);

    // R8 pair link: ch2 follows pin0
    bwr(8'h00, 8'h10);
    bwr(8'h0A, 8'd1);
    bwr(8'h03, 8'h0F);
    pulse(2, st);
    brd(8'h03, b); chk("R8 own pin ignored", 16'(b), 16'h0);
    pulse(0, s); push("R8 linked stamp", s);
    brd(8'h03, b); chk("R8 both channels flagged", 16'(b), 16'h5);
    rd16(cap_a(2), v); pop_chk(v);

    // R9 one-shot control write
    @(negedge clk); rst = 1'b1; one_shot = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    brd(8'h03, b); chk("R11 flags after reset", 16'(b), 16'h0);
    bwr(8'h00, 8'h02);
    bwr(8'h00, 8'h08);
    brd(8'h00, b); chk("R9 second write ignored", 16'(b), 16'h02);

    summary();
  end
endmodule